// File: doc/BRIEF.md
# Nibble-Decomposed Unsigned Multiplier

This block is a purely combinational unsigned multiplier that returns the full-width product of two operands. Each operand is cut into a high and a low nibble. Four nibble-by-nibble sub-multipliers form the four cross products. Each sub-multiplier sums its partial-product columns one after another, and the carry for each column comes from the column before it.

The cross products are then merged by weight. The lowest nibble of the result is wired straight from the low-by-low product. The two cross products, the upper half of the low-by-low product and the lower half of the high-by-high product are reduced by two carry-save layers into one sum vector and one carry vector. A grouped carry-lookahead adder resolves these two vectors into the middle byte. A second, narrow lookahead adder forms the top nibble. It adds the upper half of the high-by-high product to a zero-padded count of every carry that left the middle field, whether from a carry-save layer or from the middle adder.

The block holds no state. It is meant to sit between pipeline registers that belong to its host.

Top module: `nibble_mul8`

## Requirements
- R1: For every pair of operands, `prod` equals the exact unsigned product `op_a * op_b`, zero-extended to the product width.
- R2: Each nibble sub-multiplier gives the exact 2*NIB_W-bit product of its two nibbles. With only the low nibbles of both operands non-zero, `prod` equals their product. With the high nibble of `op_a` and the low nibble of `op_b` non-zero, `prod` equals that product shifted left by NIB_W.
- R3: `prod[3:0]` equals bits [3:0] of `op_a[3:0] * op_b[3:0]`. Changing the high nibbles of either operand leaves these four bits unchanged.
- R4: `prod[11:4]` includes every carry that arises when the four middle-weight terms are added. This holds for operands whose middle terms overflow across bit 7 and bit 8 of the middle field.
- R5: `prod[15:12]` equals the upper half of the high-by-high product plus all carries that left the middle field. For the all-ones operands the result is 0xFE01, and nothing is carried beyond bit 15.
- R6: When either operand is zero, `prod` is zero, whatever the other operand holds.
- R7: Swapping the operands leaves `prod` unchanged.
- R8: The block has no clock and no storage. `prod` reflects new operands within the same cycle in which they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 2*NIB_W (8) | Multiplicand, unsigned |
| op_b | input | 2*NIB_W (8) | Multiplier, unsigned |
| prod | output | 4*NIB_W (16) | Unsigned product of `op_a` and `op_b` |

## Verification
The bench builds the block with its default parameters: a nibble width of 4 and a lookahead group width of 4. At these values the operand space is only 65,536 pairs, so every pair is applied once and compared with the exact product. That covers every carry pattern through the carry-save layers and both adders. A table of hand-worked vectors and directed cases adds explicit checks of the pass-through nibble, each sub-product alone, zero operands, operand swapping and the all-ones corner.

// File: rtl/nibble_mul8_pkg.sv
package nibble_mul8_pkg;

    // Default nibble width; operands are two nibbles wide.
    localparam int unsigned DEF_NIB_W = 4;

    // Index of each cross product inside the sub-product bundle.
    localparam int unsigned XP_LL = 0;   // low(a)  * low(b)
    localparam int unsigned XP_HL = 1;   // high(a) * low(b)
    localparam int unsigned XP_LH = 2;   // low(a)  * high(b)
    localparam int unsigned XP_HH = 3;   // high(a) * high(b)
    localparam int unsigned XP_N  = 4;

    // Number of ones among three single-bit carries (0..3).
    function automatic logic [1:0] ones_of3(input logic x, input logic y, input logic z);
        ones_of3 = {1'b0, x} + {1'b0, y} + {1'b0, z};
    endfunction

endpackage

// File: rtl/nib_colmul.sv
// Nibble-by-nibble multiplier: AND array of partial products, then each
// output column is summed together with the carry count handed over from
// the column to its right.
module nib_colmul #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    localparam int unsigned PW = 2 * W;

    logic [W-1:0] pp_row [W];

    for (genvar i = 0; i < W; i++) begin : g_row
        assign pp_row[i] = x & {W{y[i]}};
    end

    always_comb begin
        int unsigned col_cnt;
        int unsigned carry_in;
        p        = '0;
        carry_in = 0;
        col_cnt  = 0;
        for (int col = 0; col < int'(PW) - 1; col++) begin
            col_cnt = carry_in;
            for (int i = 0; i < int'(W); i++) begin
                for (int j = 0; j < int'(W); j++) begin
                    if (i + j == col) begin
                        col_cnt = col_cnt + 32'(pp_row[i][j]);
                    end
                end
            end
            p[col]   = col_cnt[0];
            carry_in = col_cnt >> 1;
        end
        p[PW-1] = carry_in[0];
    end

endmodule

// File: rtl/csa3.sv
// One 3:2 carry-save layer; carry bit k has weight 2^(k+1).
module csa3 #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        assign sum_o[k] = in_x[k] ^ in_y[k] ^ in_z[k];
        assign cry_o[k] = (in_x[k] & in_y[k]) | (in_z[k] & (in_x[k] | in_y[k]));
    end
endmodule

// File: rtl/cla_adder.sv
// Grouped carry-lookahead adder. W must be a multiple of G.
module cla_adder #(
    parameter int unsigned W = 8,
    parameter int unsigned G = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    localparam int unsigned NG = W / G;

    logic [W-1:0]  gen_b;
    logic [W-1:0]  prp_b;
    logic [NG-1:0] grp_g;
    logic [NG-1:0] grp_p;
    logic [NG:0]   grp_c;

    assign gen_b = a & b;
    assign prp_b = a ^ b;

    // Group generate / propagate terms.
    always_comb begin
        for (int k = 0; k < int'(NG); k++) begin
            grp_g[k] = 1'b0;
            grp_p[k] = 1'b1;
            for (int i = 0; i < int'(G); i++) begin
                grp_g[k] = gen_b[k*G+i] | (prp_b[k*G+i] & grp_g[k]);
                grp_p[k] = grp_p[k] & prp_b[k*G+i];
            end
        end
    end

    // Carry into each group, expanded over all lower groups.
    always_comb begin
        logic term;
        grp_c[0] = cin;
        for (int k = 0; k < int'(NG); k++) begin
            grp_c[k+1] = grp_g[k];
            for (int m = k - 1; m >= -1; m--) begin
                term = (m < 0) ? cin : grp_g[m];
                for (int q = m + 1; q <= k; q++) begin
                    term = term & grp_p[q];
                end
                grp_c[k+1] = grp_c[k+1] | term;
            end
        end
    end

    // Bit sums inside each group from the group carry.
    always_comb begin
        logic c;
        s = '0;
        for (int k = 0; k < int'(NG); k++) begin
            c = grp_c[k];
            for (int i = 0; i < int'(G); i++) begin
                s[k*G+i] = prp_b[k*G+i] ^ c;
                c        = gen_b[k*G+i] | (prp_b[k*G+i] & c);
            end
        end
    end

    assign cout = grp_c[NG];

endmodule

// File: rtl/nibble_mul8.sv
module nibble_mul8
    import nibble_mul8_pkg::*;
#(
    parameter int unsigned NIB_W = DEF_NIB_W,
    parameter int unsigned GRP_W = 4
) (
    input  logic [2*NIB_W-1:0] op_a,
    input  logic [2*NIB_W-1:0] op_b,
    output logic [4*NIB_W-1:0] prod
);
    localparam int unsigned SUB_W = 2 * NIB_W;   // sub-product width
    localparam int unsigned MID_W = 2 * NIB_W;   // middle field width

    logic [NIB_W-1:0] xs [XP_N];
    logic [NIB_W-1:0] ys [XP_N];
    logic [XP_N-1:0][SUB_W-1:0] sub_p;

    assign xs[XP_LL] = op_a[NIB_W-1:0];       assign ys[XP_LL] = op_b[NIB_W-1:0];
    assign xs[XP_HL] = op_a[2*NIB_W-1:NIB_W]; assign ys[XP_HL] = op_b[NIB_W-1:0];
    assign xs[XP_LH] = op_a[NIB_W-1:0];       assign ys[XP_LH] = op_b[2*NIB_W-1:NIB_W];
    assign xs[XP_HH] = op_a[2*NIB_W-1:NIB_W]; assign ys[XP_HH] = op_b[2*NIB_W-1:NIB_W];

    for (genvar k = 0; k < XP_N; k++) begin : g_sub
        nib_colmul #(.W(NIB_W)) sub_i (
            .x (xs[k]),
            .y (ys[k]),
            .p (sub_p[k])
        );
    end

    // Middle-weight terms aligned to bit NIB_W of the product.
    logic [MID_W-1:0] term_ll, term_hl, term_lh, term_hh;
    assign term_ll = {{NIB_W{1'b0}}, sub_p[XP_LL][SUB_W-1:NIB_W]};
    assign term_hl = sub_p[XP_HL];
    assign term_lh = sub_p[XP_LH];
    assign term_hh = {sub_p[XP_HH][NIB_W-1:0], {NIB_W{1'b0}}};

    logic [MID_W-1:0] s1, c1, s2, c2;

    csa3 #(.W(MID_W)) csa0_i (
        .in_x (term_ll), .in_y (term_hl), .in_z (term_lh),
        .sum_o (s1), .cry_o (c1)
    );
    csa3 #(.W(MID_W)) csa1_i (
        .in_x (s1), .in_y ({c1[MID_W-2:0], 1'b0}), .in_z (term_hh),
        .sum_o (s2), .cry_o (c2)
    );

    logic [MID_W-1:0] mid_byte;
    logic             mid_cout;

    cla_adder #(.W(MID_W), .G(GRP_W)) mid_add_i (
        .a (s2), .b ({c2[MID_W-2:0], 1'b0}), .cin (1'b0),
        .s (mid_byte), .cout (mid_cout)
    );

    // All carries leaving the middle field go to the top nibble.
    logic [1:0]       ovf_cnt;
    logic [NIB_W-1:0] top_nib;
    logic             top_cout;

    assign ovf_cnt = ones_of3(c1[MID_W-1], c2[MID_W-1], mid_cout);

    cla_adder #(.W(NIB_W), .G(NIB_W)) top_add_i (
        .a (sub_p[XP_HH][SUB_W-1:NIB_W]), .b ({{(NIB_W-2){1'b0}}, ovf_cnt}), .cin (1'b0),
        .s (top_nib), .cout (top_cout)
    );

    assign prod = {top_nib, mid_byte, sub_p[XP_LL][NIB_W-1:0]};

endmodule

// File: rtl/nibble_mul8_chk.sv
module nibble_mul8_chk #(
    parameter int unsigned NIB_W = 4
) (
    input logic [2*NIB_W-1:0]        op_a,
    input logic [2*NIB_W-1:0]        op_b,
    input logic [4*NIB_W-1:0]        prod,
    input logic [3:0][2*NIB_W-1:0]   sub_p,
    input logic [2*NIB_W-1:0]        s2,
    input logic [2*NIB_W-1:0]        c2,
    input logic [2*NIB_W-1:0]        c1,
    input logic                      top_cout
);
    localparam int unsigned OW = 2 * NIB_W;
    localparam int unsigned PW = 4 * NIB_W;

    logic [PW-1:0] ref_p;
    logic [OW-1:0] al, ah, bl, bh;
    logic [PW-1:0] mid_ref, mid_csa;

    always_comb begin
        ref_p   = {{OW{1'b0}}, op_a} * {{OW{1'b0}}, op_b};
        al      = {{NIB_W{1'b0}}, op_a[NIB_W-1:0]};
        ah      = {{NIB_W{1'b0}}, op_a[OW-1:NIB_W]};
        bl      = {{NIB_W{1'b0}}, op_b[NIB_W-1:0]};
        bh      = {{NIB_W{1'b0}}, op_b[OW-1:NIB_W]};
        mid_ref = PW'((al * bl) >> NIB_W) + PW'(ah * bl) + PW'(al * bh)
                + (PW'((ah * bh) & ((OW'(1) << NIB_W) - OW'(1))) << NIB_W);
        mid_csa = PW'(s2) + (PW'(c2) << 1) + (PW'(c1[OW-1]) << OW);
    end

    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            // R1
            full_product_chk: assert (prod == ref_p)
                else $error("product mismatch");
            // R2
            sub_ll_chk: assert (sub_p[0] == al * bl) else $error("ll sub-product");
            // R2
            sub_hl_chk: assert (sub_p[1] == ah * bl) else $error("hl sub-product");
            // R2
            sub_lh_chk: assert (sub_p[2] == al * bh) else $error("lh sub-product");
            // R2
            sub_hh_chk: assert (sub_p[3] == ah * bh) else $error("hh sub-product");
            // R3
            low_nibble_chk: assert (prod[NIB_W-1:0] == OW'(al * bl) % (OW'(1) << NIB_W))
                else $error("low nibble");
            // R4
            csa_sum_chk: assert (mid_csa == mid_ref)
                else $error("carry-save reduction lost weight");
            // R5
            no_overflow_chk: assert (!top_cout)
                else $error("carry beyond product width");
            // R6
            zero_operand_chk: assert (!((op_a == '0) || (op_b == '0)) || (prod == '0))
                else $error("zero operand");
        end
    end

endmodule

bind nibble_mul8 nibble_mul8_chk #(.NIB_W(NIB_W)) chk_i (
    .op_a     (op_a),
    .op_b     (op_b),
    .prod     (prod),
    .sub_p    (sub_p),
    .s2       (s2),
    .c2       (c2),
    .c1       (c1),
    .top_cout (top_cout)
);

// File: tb/nibble_mul8_tb_top.sv
module nibble_mul8_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;
    localparam int NVEC       = 12;

    // {op_a, op_b, expected product}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 16'h0000},
        {8'hFF, 8'hFF, 16'hFE01},
        {8'h0F, 8'h0F, 16'h00E1},
        {8'hF0, 8'hF0, 16'hE100},
        {8'h0F, 8'hF0, 16'h0E10},
        {8'h80, 8'h80, 16'h4000},
        {8'h12, 8'h34, 16'h03A8},
        {8'hAB, 8'hCD, 16'h88EF},
        {8'h01, 8'hFF, 16'h00FF},
        {8'hFF, 8'h02, 16'h01FE},
        {8'h11, 8'h11, 16'h0121},
        {8'h7F, 8'h81, 16'h3FFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_a = 8'h00;
    logic [7:0]  op_b = 8'h00;
    logic [15:0] prod;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    nibble_mul8 dut_i (.op_a(op_a), .op_b(op_b), .prod(prod));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s a=%02h b=%02h actual=%04h expected=%04h", req, op_a, op_b, got, exp);
        end
    endtask

    // Drive on the rising edge, sample at the following falling edge.
    task automatic apply(input logic [7:0] a, input logic [7:0] b);
        @(posedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] p_ab;

        // Reset state: zero operands held through reset (R6, R8)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset", prod, 16'h0000);
        rst_n = 1'b1;

        // Table of hand-worked vectors (R1, R4, R5)
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][31:24], VEC[v][23:16]);
            check("R1 table", prod, VEC[v][15:0]);
        end

        // Middle field carries into bit 8 and beyond (R4)
        apply(8'hFF, 8'h1F);                     // 255*31 = 7905
        check("R4 mid carry", prod, 16'h1EE1);
        apply(8'hEF, 8'hFE);                     // 239*254 = 60706
        check("R4 mid carry", prod, 16'hED22);

        // All-ones corner and top nibble (R5)
        apply(8'hFF, 8'hFF);
        check("R5 top nibble", prod, 16'hFE01);
        apply(8'hF8, 8'hF8);                     // 248*248 = 61504
        check("R5 top nibble", prod, 16'hF040);

        // Individual sub-products (R2)
        apply(8'h0D, 8'h0B);
        check("R2 low*low", prod, 16'd143);
        apply(8'hD0, 8'h0B);
        check("R2 high*low", prod, 16'(143 << 4));
        apply(8'h0D, 8'hB0);
        check("R2 low*high", prod, 16'(143 << 4));
        apply(8'hD0, 8'hB0);
        check("R2 high*high", prod, 16'(143 << 8));

        // Low nibble ignores the high nibbles (R3)
        for (int h = 0; h < 16; h++) begin
            apply({h[3:0], 4'h7}, {4'(15 - h), 4'h9});   // 7*9 = 63 -> low nibble F
            check("R3 low nibble", {12'h000, prod[3:0]}, 16'h000F);
        end

        // Zero operand with non-zero partner (R6)
        apply(8'h00, 8'hA5);
        check("R6 zero a", prod, 16'h0000);
        apply(8'h5A, 8'h00);
        check("R6 zero b", prod, 16'h0000);

        // Operand swap (R7)
        apply(8'h3C, 8'hE7);
        p_ab = prod;
        apply(8'hE7, 8'h3C);
        check("R7 swap", prod, p_ab);

        // Same-cycle response after a change (R8)
        apply(8'h02, 8'h03);
        check("R8 settle", prod, 16'd6);
        apply(8'hC8, 8'h64);                     // 200*100
        check("R8 settle", prod, 16'd20000);

        // Every operand pair (R1)
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                apply(ia[7:0], ib[7:0]);
                check("R1 exhaustive", prod, 16'(ia * ib));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule